// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a stereo serial audio stream into parallel samples. One serial data line carries two's-complement words, most significant bit first, and a frame clock marks each channel's half of the frame. The bit clock comes from one of two places. It can be an external bit-clock pin, sampled on a selectable edge. It can also be a clock-enable made inside the block from the master clock, at a rate set by the master-to-frame ratio and the word length. Three framings are accepted: right-justified, left-justified and I2S. Words are 16 or 18 bits long.

The whole block runs in the master-clock domain. The frame clock, the data line and the external bit clock are sampled on master-clock edges. The block does not detect the master-to-frame ratio; that ratio arrives as an input code. After each right word ends, the block presents the left and right words of that frame together and raises a valid strobe for one cycle. Both words are sign-extended to 18 bits.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is held and right after it is released, `valid_o` is 0 and `left_o` and `right_o` are 0.
- R2: With `ext_mode_i`=0, the master clock runs 256, 384 or 512 cycles per frame-clock period for `ratio_i` = 0, 1 or 2. The number of bit slots per frame is 48 when `ratio_i`=1. Otherwise it is 64 for 18-bit words and 32 for 16-bit words. Each slot lasts ratio/slots master cycles. A slot is sampled halfway through it, counting from the first master edge that sees the new frame-clock level.
- R3: With `fmt_i`=0 (right-justified; code 3 acts the same), the word is the last N bits received before a frame-clock change. Any bits before them in that half are discarded.
- R4: With `fmt_i`=1 (left-justified), the MSB is in the first bit slot after a frame-clock change, and the N-1 slots that follow hold the rest of the word. Later slots are ignored.
- R5: With `fmt_i`=2 (I2S), the MSB is in the second slot after a frame-clock change. When a half holds exactly N slots, the LSB is taken from the first slot of the next half.
- R6: In right- and left-justified framing, a frame-clock level of 1 carries the left word. In I2S, a level of 0 carries the left word.
- R7: With `short_word_i`=1 words are 16 bits long, and the outputs hold them sign-extended to 18 bits. With `short_word_i`=0 words are 18 bits long.
- R8: With `ext_mode_i`=1, data is sampled on rising edges of `ext_sclk_i`, or on falling edges when `fall_edge_i`=1. The frame clock changes on the edge that is not sampled. With `ext_mode_i`=0, `fall_edge_i` has no effect.
- R9: After each right word completes, `valid_o` is 1 for exactly one cycle. In that cycle `left_o` and `right_o` hold the frame's left and right words. Both outputs keep their values until the next pulse.
- R10: After reset, no pulse appears until a complete left word and then a complete right word have been received. A right word without a left word before it gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock; every register runs on it |
| rst_n | input | 1 | Active-low synchronous reset |
| lrck_i | input | 1 | Frame clock; its level selects the channel |
| sdata_i | input | 1 | Serial audio data |
| ext_sclk_i | input | 1 | External bit clock |
| ext_mode_i | input | 1 | 1: external bit clock, 0: internal bit clock |
| fall_edge_i | input | 1 | External mode: 1 samples on falling edges |
| fmt_i | input | 2 | 0 right-justified, 1 left-justified, 2 I2S, 3 as 0 |
| short_word_i | input | 1 | 1: 16-bit words, 0: 18-bit words |
| ratio_i | input | 2 | Master cycles per frame: 0=256, 1=384, 2=512 |
| left_o | output | 18 | Left sample, sign-extended |
| right_o | output | 18 | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle strobe when a sample pair is ready |

## Verification
The bench sweeps every framing and word length at all three master ratios, and it also covers both external sampling edges. Half-frames are padded with alternating filler bits. A right-justified receiver that kept bits from the front of a half, or a left-justified one that kept shifting past N bits, would then deliver corrupted words. The I2S case with exactly N slots per half puts the LSB across the frame-clock change. A receiver that closed the word at that change would lose the last bit and deliver every word off by one position. Negative 16-bit words expose a missing sign extension. A per-configuration pulse count catches a spurious pair at startup, which would come from a right word that had no left word before it.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

  localparam int WORD_W  = 18;
  localparam int SHORT_W = 16;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_I2S = 2'd2,
    FMT_RSV = 2'd3
  } fmt_e;

  // master clock cycles in one frame clock period
  function automatic logic [9:0] mclk_per_frame(input logic [1:0] ratio);
    case (ratio)
      2'd0:    return 10'd256;
      2'd1:    return 10'd384;
      default: return 10'd512;
    endcase
  endfunction

  // internal bit clocks per frame clock period
  function automatic logic [6:0] bits_per_frame(input logic [1:0] ratio, input logic short_w);
    if (ratio == 2'd1) return 7'd48;
    else if (!short_w) return 7'd64;
    else               return 7'd32;
  endfunction

  // master cycles per internal bit slot
  function automatic logic [4:0] bit_div(input logic [1:0] ratio, input logic short_w);
    return 5'(mclk_per_frame(ratio) / {3'b000, bits_per_frame(ratio, short_w)});
  endfunction

  function automatic logic [4:0] word_len(input logic short_w);
    return short_w ? 5'(SHORT_W) : 5'(WORD_W);
  endfunction

  function automatic logic left_level(input logic lvl, input logic i2s);
    return i2s ? ~lvl : lvl;
  endfunction

  function automatic logic [WORD_W-1:0] widen(input logic [WORD_W-1:0] v, input logic short_w);
    return short_w ? {{(WORD_W-SHORT_W){v[SHORT_W-1]}}, v[SHORT_W-1:0]} : v;
  endfunction

endpackage

// File: rtl/audio_rx_bitclk.sv
module audio_rx_bitclk
  import audio_rx_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lrck_i,
  input  logic       ext_sclk_i,
  input  logic       ext_mode_i,
  input  logic       fall_edge_i,
  input  logic       short_word_i,
  input  logic [1:0] ratio_i,
  output logic       lrck_edge_o,
  output logic       lrck_lvl_o,
  output logic       bit_tick_o
);

  logic             lrck_q;
  logic             sclk_q;
  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] pos_now;
  logic [4:0]       div;
  logic             int_tick;
  logic             ext_rise;
  logic             ext_fall;
  logic             ext_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lrck_q <= 1'b0;
      sclk_q <= 1'b0;
      pos_q  <= '0;
    end else begin
      lrck_q <= lrck_i;
      sclk_q <= ext_sclk_i;
      pos_q  <= pos_now + CNT_W'(1);
    end
  end

  assign lrck_edge_o = lrck_i ^ lrck_q;
  assign lrck_lvl_o  = lrck_q;

  // position inside the current half frame, 0 on the edge cycle
  assign pos_now  = lrck_edge_o ? '0 : pos_q;
  assign div      = bit_div(ratio_i, short_word_i);
  assign int_tick = ((pos_now & CNT_W'(div - 5'd1)) == CNT_W'(div >> 1));

  assign ext_rise = ext_sclk_i & ~sclk_q;
  assign ext_fall = ~ext_sclk_i & sclk_q;
  assign ext_tick = fall_edge_i ? ext_fall : ext_rise;

  assign bit_tick_o = ext_mode_i ? ext_tick : int_tick;

  // R2
  int_tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode_i && bit_tick_o) |=> (!bit_tick_o || ext_mode_i));

  // R8
  ext_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode_i && bit_tick_o) |-> (ext_sclk_i == !fall_edge_i));

endmodule

// File: rtl/audio_rx_frame.sv
module audio_rx_frame
  import audio_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lrck_edge_i,
  input  logic              lrck_lvl_i,
  input  logic              bit_tick_i,
  input  logic              sdata_i,
  input  logic [1:0]        fmt_i,
  input  logic              short_word_i,
  output logic              cap_o,
  output logic              cap_left_o,
  output logic [WORD_W-1:0] cap_word_o
);

  fmt_e              fmt;
  logic              rj;
  logic              i2s;
  logic [4:0]        nbits;
  logic [WORD_W-1:0] sr_q, sr_d, shifted;
  logic [4:0]        rem_q, rem_d;
  logic              start_q, start_d;
  logic              seen_q, seen_d;
  logic              chan_q, chan_d;

  assign fmt     = fmt_e'(fmt_i);
  assign i2s     = (fmt == FMT_I2S);
  assign rj      = (fmt == FMT_RJ) || (fmt == FMT_RSV);
  assign nbits   = word_len(short_word_i);
  assign shifted = {sr_q[WORD_W-2:0], sdata_i};

  always_comb begin
    sr_d       = sr_q;
    rem_d      = rem_q;
    start_d    = start_q;
    seen_d     = seen_q;
    chan_d     = chan_q;
    cap_o      = 1'b0;
    cap_left_o = 1'b0;
    if (rj) begin
      // keep shifting; the word is whatever the last N bits were
      if (bit_tick_i) sr_d = shifted;
      if (lrck_edge_i) begin
        seen_d = 1'b1;
        if (seen_q) begin
          cap_o      = 1'b1;
          cap_left_o = left_level(lrck_lvl_i, 1'b0);
        end
      end
    end else begin
      if (lrck_edge_i) start_d = 1'b1;
      if (bit_tick_i) begin
        if (rem_q != 5'd0) begin
          sr_d  = shifted;
          rem_d = rem_q - 5'd1;
          if (rem_q == 5'd1) begin
            cap_o      = 1'b1;
            cap_left_o = chan_q;
          end
        end
        if (start_q) begin
          // first bit slot of a new half frame
          start_d = 1'b0;
          chan_d  = left_level(lrck_lvl_i, i2s);
          if (i2s) begin
            rem_d = nbits;
          end else begin
            sr_d  = shifted;
            rem_d = nbits - 5'd1;
          end
        end
      end
    end
  end

  assign cap_word_o = widen(rj ? sr_q : sr_d, short_word_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q    <= '0;
      rem_q   <= '0;
      start_q <= 1'b0;
      seen_q  <= 1'b0;
      chan_q  <= 1'b0;
    end else begin
      sr_q    <= sr_d;
      rem_q   <= rem_d;
      start_q <= start_d;
      seen_q  <= seen_d;
      chan_q  <= chan_d;
    end
  end

  // R5
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= 5'(WORD_W));

  // R4
  framed_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_o && !rj) |-> bit_tick_i);

  // R3
  cap_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o |=> !cap_o);

endmodule

// File: rtl/audio_rx_pair.sv
module audio_rx_pair
  import audio_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic              cap_left_i,
  input  logic [WORD_W-1:0] cap_word_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);

  logic [WORD_W-1:0] stage_q;
  logic              have_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      have_q  <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap_i && cap_left_i) begin
        stage_q <= cap_word_i;
        have_q  <= 1'b1;
      end else if (cap_i) begin
        have_q <= 1'b0;
        if (have_q) begin
          left_o  <= stage_q;
          right_o <= cap_word_i;
          valid_o <= 1'b1;
        end
      end
    end
  end

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  // R10
  pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(have_q));

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import audio_rx_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              mclk_i,
  input  logic              rst_n,
  input  logic              lrck_i,
  input  logic              sdata_i,
  input  logic              ext_sclk_i,
  input  logic              ext_mode_i,
  input  logic              fall_edge_i,
  input  logic [1:0]        fmt_i,
  input  logic              short_word_i,
  input  logic [1:0]        ratio_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);

  logic              lrck_edge;
  logic              lrck_lvl;
  logic              bit_tick;
  logic              cap;
  logic              cap_left;
  logic [WORD_W-1:0] cap_word;

  audio_rx_bitclk #(.CNT_W(CNT_W)) i_bitclk (
    .clk          (mclk_i),
    .rst_n        (rst_n),
    .lrck_i       (lrck_i),
    .ext_sclk_i   (ext_sclk_i),
    .ext_mode_i   (ext_mode_i),
    .fall_edge_i  (fall_edge_i),
    .short_word_i (short_word_i),
    .ratio_i      (ratio_i),
    .lrck_edge_o  (lrck_edge),
    .lrck_lvl_o   (lrck_lvl),
    .bit_tick_o   (bit_tick)
  );

  audio_rx_frame i_frame (
    .clk          (mclk_i),
    .rst_n        (rst_n),
    .lrck_edge_i  (lrck_edge),
    .lrck_lvl_i   (lrck_lvl),
    .bit_tick_i   (bit_tick),
    .sdata_i      (sdata_i),
    .fmt_i        (fmt_i),
    .short_word_i (short_word_i),
    .cap_o        (cap),
    .cap_left_o   (cap_left),
    .cap_word_o   (cap_word)
  );

  audio_rx_pair i_pair (
    .clk        (mclk_i),
    .rst_n      (rst_n),
    .cap_i      (cap),
    .cap_left_i (cap_left),
    .cap_word_i (cap_word),
    .left_o     (left_o),
    .right_o    (right_o),
    .valid_o    (valid_o)
  );

endmodule

// File: tb/test_audio_serial_rx.sv
module test_audio_serial_rx;

  localparam int CLK_P     = 10;
  localparam int SCLK_HALF = 2;
  localparam int FRAMES    = 3;
  localparam int WDOG      = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lrck = 1'b0, sdata = 1'b0, sclk = 1'b0;
  logic        ext = 1'b0, fall = 1'b0, short_w = 1'b0;
  logic [1:0]  fmt = 2'd0, ratio = 2'd0;
  logic [17:0] left_o, right_o;
  logic        valid_o;

  int checks = 0, fails = 0;
  int vcount = 0;
  bit running = 0, done = 0;
  logic [17:0] exp_l [FRAMES], exp_r [FRAMES];
  string tag_fmt = "R3", tag_mode = "R2", tag_len = "R7";

  always #(CLK_P/2) clk = ~clk;

  audio_serial_rx i_audio_serial_rx (
    .mclk_i(clk), .rst_n(rst_n), .lrck_i(lrck), .sdata_i(sdata),
    .ext_sclk_i(sclk), .ext_mode_i(ext), .fall_edge_i(fall), .fmt_i(fmt),
    .short_word_i(short_w), .ratio_i(ratio),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  task automatic check(input bit ok, input string tag, input logic [17:0] act, input logic [17:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (fmt=%0d short=%0d ratio=%0d ext=%0d fall=%0d)",
               tag, act, expv, fmt, short_w, ratio, ext, fall);
    end
  endtask

  // sign extension done arithmetically
  function automatic logic [17:0] expect_word(input logic [17:0] w, input int n);
    int v = int'(w);
    if (v >= (1 << (n-1))) v = v + (1 << 18) - (1 << n);
    return 18'(v);
  endfunction

  function automatic logic slot_bit(input int k, input int s, input int n,
                                    input logic [17:0] w, input logic [17:0] pw);
    logic pad = k[0];
    case (fmt)
      2'd1:    return (k < n) ? w[n-1-k] : pad;
      2'd2: begin
        if (k == 0) return (s == n) ? pw[0] : pad;
        return (k <= n) ? w[n-k] : pad;
      end
      default: return (k >= s-n) ? w[n-1-(k-(s-n))] : pad;
    endcase
  endfunction

  task automatic send_half(input logic lvl, input logic [17:0] w, input logic [17:0] pw,
                           input int s, input int n, input int d);
    for (int k = 0; k < s; k++) begin
      lrck  = lvl;
      sdata = slot_bit(k, s, n, w, pw);
      if (ext) begin
        sclk = fall;
        repeat (SCLK_HALF) @(negedge clk);
        sclk = ~fall;
        repeat (SCLK_HALF) @(negedge clk);
      end else begin
        repeat (d) @(negedge clk);
      end
    end
  endtask

  always @(negedge clk) begin
    if (running && valid_o) begin
      if (vcount < FRAMES) begin
        check(left_o == exp_l[vcount], $sformatf("R6 left %s %s %s", tag_fmt, tag_mode, tag_len),
              left_o, exp_l[vcount]);
        check(right_o == exp_r[vcount], $sformatf("R6 right %s %s %s", tag_fmt, tag_mode, tag_len),
              right_o, exp_r[vcount]);
      end else begin
        check(1'b0, "R9 extra pulse", 18'(vcount), 18'(FRAMES));
      end
      vcount++;
    end
  end

  task automatic run_cfg(input logic [1:0] f, input logic sh, input logic [1:0] r,
                         input logic e, input logic fl);
    int n, s, d;
    logic rlvl;
    logic [17:0] prev, wl [FRAMES], wr [FRAMES];
    fmt = f; short_w = sh; ratio = r; ext = e; fall = fl;
    n = sh ? 16 : 18;
    if (e) s = fl ? n : n + 3;
    else if (r == 2'd1) s = 24;
    else s = sh ? 16 : 32;
    d = (128 * (int'(r) + 2)) / (2 * s);
    tag_fmt  = (f == 2'd1) ? "R4" : (f == 2'd2) ? "R5" : "R3";
    tag_mode = e ? "R8" : "R2";
    tag_len  = sh ? "R7 16b" : "R7 18b";
    rlvl = (f == 2'd2);
    for (int i = 0; i < FRAMES; i++) begin
      wl[i] = 18'($urandom) & 18'((1 << n) - 1);
      wr[i] = 18'($urandom) & 18'((1 << n) - 1);
      if (i == 0) wl[i] = 18'(1 << (n-1));
      exp_l[i] = expect_word(wl[i], n);
      exp_r[i] = expect_word(wr[i], n);
    end
    @(negedge clk);
    rst_n = 1'b0; lrck = rlvl; sdata = 1'b0; sclk = fl;
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R1 valid", 18'(valid_o), 18'd0);
    check(left_o == 18'd0 && right_o == 18'd0, "R1 outputs", left_o | right_o, 18'd0);
    rst_n = 1'b1;
    vcount = 0;
    running = 1;
    @(negedge clk);
    check(valid_o == 1'b0 && left_o == 18'd0, "R1 after release", left_o, 18'd0);
    prev = '0;
    send_half(rlvl, 18'd0, prev, s, n, d);
    for (int i = 0; i < FRAMES; i++) begin
      send_half(~rlvl, wl[i], prev, s, n, d);
      prev = wl[i];
      send_half(rlvl, wr[i], prev, s, n, d);
      prev = wr[i];
    end
    send_half(~rlvl, 18'd0, prev, s, n, d);
    repeat (8) @(negedge clk);
    running = 0;
    check(vcount == FRAMES, $sformatf("R9 R10 pulse count %s %s", tag_fmt, tag_mode),
          18'(vcount), 18'(FRAMES));
  endtask

  initial begin
    // internal bit clock: all framings, lengths and ratios; fall_edge toggled (ignored, R8)
    for (int f = 0; f < 3; f++)
      for (int sh = 0; sh < 2; sh++)
        for (int r = 0; r < 3; r++)
          run_cfg(2'(f), 1'(sh), 2'(r), 1'b0, 1'(r & 1));
    // external bit clock: both sampling edges
    for (int f = 0; f < 3; f++)
      for (int sh = 0; sh < 2; sh++)
        for (int fl = 0; fl < 2; fl++)
          run_cfg(2'(f), 1'(sh), 2'd0, 1'b1, 1'(fl));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired R9 actual=%0d expected=%0d", vcount, FRAMES);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule